// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block holds a small set of reservation stations in front of one pipelined add/subtract functional unit. Each cycle the issue side may offer one operation with two source operands. Each source arrives either as a value or as the tag of the station that will produce it. The bank places the operation in the lowest-numbered free station. That station then watches the shared result broadcast bus, and whenever the bus tag equals one of its pending producer tags it copies the bus data into that operand and clears the tag.

Readiness needs no separate flag: a station can go to the unit once both of its producer tags are zero. When several stations are ready, the one issued earliest is offered to the unit, and at most one station leaves per cycle, with a ready/valid handshake. A dispatched station stays occupied until the unit's result appears on the broadcast bus carrying that station's own tag. The station is then released.

Every station carries a fixed, nonzero tag equal to `TAG_BASE` plus its index, so several banks can share one tag space. Each station runs a three-state machine. In `ST_FREE` the station is empty. `ST_FREE` moves to `ST_WAIT` on allocation. In `ST_WAIT` the station holds operands and snoops the bus. `ST_WAIT` moves to `ST_EXEC` when the station is granted and the unit accepts. In `ST_EXEC` the station is in the unit. `ST_EXEC` moves to `ST_FREE` when the bus carries the station's own tag.

Top module: `rs_bank`

## Requirements
- R1: After reset every station is free: `iss_ready` is 1, `iss_tag` equals `TAG_BASE`, and `disp_valid` is 0.
- R2: `iss_ready` is 1 exactly when at least one station is free. An issue offered while no station is free is ignored and leaves every station unchanged.
- R3: A source with tag 0 is taken as valid from its value input. A source with a nonzero tag is not valid until that tag is seen on the broadcast bus.
- R4: `disp_valid` is 1 only when some occupied, not-yet-dispatched station has both producer tags equal to 0.
- R5: A waiting station whose pending tag equals `cdb_tag` while `cdb_valid` is 1 takes `cdb_data` into that operand at the clock edge. After that edge the operand is valid.
- R6: If a source tag offered at issue is broadcast in that same cycle, the bus data is stored as the operand and the operand is valid from the next cycle.
- R7: Among ready stations, the one issued earliest is offered on `disp_tag`, `disp_a`, `disp_b` and `disp_sub`. It leaves only when `disp_valid` and `disp_ready` are both 1, and at most one station leaves per cycle.
- R8: Station i has tag `TAG_BASE`+i, which is never 0. `iss_tag` gives the tag of the station an issue would take, which is the lowest-numbered free one. A dispatched station becomes free on the edge where its own tag is broadcast.
- R9: The operation bit is stored at issue and presented on `disp_sub`: 0 selects add, 1 selects subtract.
- R10: A broadcast whose tag names a station that has not yet been dispatched does not free that station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_sub | input | 1 | Operation: 0 add, 1 subtract |
| iss_vj | input | DATA_W | First source value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | First source producer tag, 0 if valid |
| iss_vk | input | DATA_W | Second source value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | Second source producer tag, 0 if valid |
| iss_ready | output | 1 | A free station exists |
| iss_tag | output | TAG_W | Tag of the station the next issue takes (0 when full) |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the producing station |
| cdb_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready station is offered to the unit |
| disp_ready | input | 1 | Unit accepts the offered station |
| disp_sub | output | 1 | Operation of the offered station |
| disp_a | output | DATA_W | First operand of the offered station |
| disp_b | output | DATA_W | Second operand of the offered station |
| disp_tag | output | TAG_W | Tag of the offered station |

## Verification
Random traffic mixes sources that are already valid, sources waiting on stations of this bank, and sources waiting on foreign tags. It also mixes broadcasts of station results and of foreign results, while the unit accepts irregularly. This tells correct snooping and age order apart from designs that only work when operands arrive in issue order. Directed cases separate the following behaviours:
- capture at the issue cycle from capture one cycle later;
- a full bank that ignores issue from one that overwrites a station;
- a broadcast of a waiting station's tag that frees it from one that does not;
- three stations made ready in the same cycle, which shows whether dispatch follows age or index.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } rs_state_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } rs_op_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter logic [TAG_W-1:0] MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  rs_op_e            op_i,
    input  logic [DATA_W-1:0] vj_i,
    input  logic [TAG_W-1:0]  qj_i,
    input  logic [DATA_W-1:0] vk_i,
    input  logic [TAG_W-1:0]  qk_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              exec_o,
    output logic              ready_o,
    output rs_op_e            op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o
);
    rs_state_e         state_q, state_d;
    rs_op_e            op_q;
    logic [DATA_W-1:0] vj_q, vk_q;
    logic [TAG_W-1:0]  qj_q, qk_q;
    logic              hit_iss_j, hit_iss_k, hit_j, hit_k;

    // snoop matches for incoming sources and for held tags
    assign hit_iss_j = bc_valid_i && (qj_i != '0) && (bc_tag_i == qj_i);
    assign hit_iss_k = bc_valid_i && (qk_i != '0) && (bc_tag_i == qk_i);
    assign hit_j     = bc_valid_i && (qj_q != '0) && (bc_tag_i == qj_q);
    assign hit_k     = bc_valid_i && (qk_q != '0) && (bc_tag_i == qk_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (alloc_i) state_d = ST_WAIT;
            ST_WAIT: if (grant_i) state_d = ST_EXEC;
            ST_EXEC: if (bc_valid_i && bc_tag_i == MY_TAG) state_d = ST_FREE;
            default: state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_ADD;
            vj_q <= '0;
            vk_q <= '0;
            qj_q <= '0;
            qk_q <= '0;
        end else if (state_q == ST_FREE && alloc_i) begin
            op_q <= op_i;
            vj_q <= hit_iss_j ? bc_data_i : vj_i;
            qj_q <= hit_iss_j ? '0 : qj_i;
            vk_q <= hit_iss_k ? bc_data_i : vk_i;
            qk_q <= hit_iss_k ? '0 : qk_i;
        end else if (state_q == ST_WAIT) begin
            if (hit_j) begin
                vj_q <= bc_data_i;
                qj_q <= '0;
            end
            if (hit_k) begin
                vk_q <= bc_data_i;
                qk_q <= '0;
            end
        end
    end

    always_comb begin
        busy_o  = (state_q != ST_FREE);
        exec_o  = (state_q == ST_EXEC);
        ready_o = (state_q == ST_WAIT) && (qj_q == '0) && (qk_q == '0);
        op_o    = op_q;
        vj_o    = vj_q;
        vk_o    = vk_q;
    end
endmodule

// File: rtl/rs_first_free.sv
module rs_first_free #(
    parameter int N = 3
) (
    input  logic [N-1:0] free_i,
    output logic [N-1:0] sel_o,
    output logic         any_o
);
    logic found;
    always_comb begin
        sel_o = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (free_i[i] && !found) begin
                sel_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any_o = |free_i;
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_i,
    input  logic [N-1:0] ready_i,
    output logic [N-1:0] pick_o
);
    // older_q[a][b] set: station a was issued before station b
    logic [N-1:0][N-1:0] older_q;
    logic [N-1:0]        blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc_i[k]) begin
                    for (int j = 0; j < N; j++) begin
                        older_q[k][j] <= 1'b0;
                        if (j != k) older_q[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        blocked = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (j != i && ready_i[j] && older_q[j][i]) blocked[i] = 1'b1;
            end
        end
        pick_o = ready_i & ~blocked;
    end
endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_pkg::*;
#(
    parameter int NUM_RS   = 3,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic              iss_sub,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic              disp_sub,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);
    logic [NUM_RS-1:0] ent_busy, ent_exec, ent_ready;
    logic [NUM_RS-1:0] free_sel, alloc, pick, grant;
    rs_op_e            ent_op [NUM_RS];
    logic [DATA_W-1:0] ent_vj [NUM_RS];
    logic [DATA_W-1:0] ent_vk [NUM_RS];

    rs_first_free #(.N(NUM_RS)) i_free (
        .free_i (~ent_busy),
        .sel_o  (free_sel),
        .any_o  (iss_ready)
    );

    assign alloc = iss_valid ? free_sel : '0;
    assign grant = disp_ready ? pick : '0;

    for (genvar g = 0; g < NUM_RS; g++) begin : g_ent
        localparam logic [TAG_W-1:0] ENT_TAG = TAG_W'(TAG_BASE + g);
        rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(ENT_TAG)) i_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc[g]),
            .op_i       (rs_op_e'(iss_sub)),
            .vj_i       (iss_vj),
            .qj_i       (iss_qj),
            .vk_i       (iss_vk),
            .qk_i       (iss_qk),
            .bc_valid_i (cdb_valid),
            .bc_tag_i   (cdb_tag),
            .bc_data_i  (cdb_data),
            .grant_i    (grant[g]),
            .busy_o     (ent_busy[g]),
            .exec_o     (ent_exec[g]),
            .ready_o    (ent_ready[g]),
            .op_o       (ent_op[g]),
            .vj_o       (ent_vj[g]),
            .vk_o       (ent_vk[g])
        );
    end

    rs_age_pick #(.N(NUM_RS)) i_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_i (alloc),
        .ready_i (ent_ready),
        .pick_o  (pick)
    );

    always_comb begin
        iss_tag = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (free_sel[i]) iss_tag = TAG_W'(TAG_BASE + i);
        end
    end

    always_comb begin
        disp_valid = |pick;
        disp_sub   = 1'b0;
        disp_a     = '0;
        disp_b     = '0;
        disp_tag   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (pick[i]) begin
                disp_sub = (ent_op[i] == OP_SUB);
                disp_a   = ent_vj[i];
                disp_b   = ent_vk[i];
                disp_tag = TAG_W'(TAG_BASE + i);
            end
        end
    end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
    parameter int NUM_RS   = 3,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_ready,
    input logic [TAG_W-1:0]  iss_tag,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [NUM_RS-1:0] ent_busy,
    input logic [NUM_RS-1:0] ent_exec,
    input logic [NUM_RS-1:0] pick
);
    AST_FULL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_busy) |-> !iss_ready); // R2
    AST_EMPTY_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_busy == '0) |-> !disp_valid); // R4
    AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick)); // R7
    AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |-> (iss_tag != '0)); // R8

    for (genvar g = 0; g < NUM_RS; g++) begin : g_chk
        localparam logic [TAG_W-1:0] ENT_TAG = TAG_W'(TAG_BASE + g);
        AST_GRANT_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
            (pick[g] && disp_ready) |=> ent_exec[g]); // R7
        AST_FREE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && cdb_tag == ENT_TAG && ent_exec[g]) |=> !ent_busy[g]); // R8
        AST_WAIT_NOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_busy[g] && !ent_exec[g] && !(pick[g] && disp_ready)) |=> ent_busy[g]); // R10
    end
endmodule

bind rs_bank rs_bank_chk #(.NUM_RS(NUM_RS), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_ready  (iss_ready),
    .iss_tag    (iss_tag),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .ent_busy   (ent_busy),
    .ent_exec   (ent_exec),
    .pick       (pick)
);

// File: tb/test_rs_bank.sv
module test_rs_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int DW = 64;
    localparam int TW = 4;
    localparam int TB = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          iss_valid, iss_sub, iss_ready;
    logic [DW-1:0] iss_vj, iss_vk;
    logic [TW-1:0] iss_qj, iss_qk, iss_tag;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [DW-1:0] cdb_data;
    logic          disp_valid, disp_ready, disp_sub;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model: 0 free, 1 waiting, 2 dispatched
    int          m_st  [N];
    int          m_seq [N];
    logic [DW-1:0] m_vj [N];
    logic [DW-1:0] m_vk [N];
    logic [TW-1:0] m_qj [N];
    logic [TW-1:0] m_qk [N];
    logic        m_op  [N];
    int          seq_ctr;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_bank #(.NUM_RS(N), .DATA_W(DW), .TAG_W(TW), .TAG_BASE(TB)) i_rs_bank (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_sub(iss_sub),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_sub(disp_sub),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int exp_free();
        for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    function automatic int exp_pick();
        int p = -1;
        for (int i = 0; i < N; i++)
            if (m_st[i] == 1 && m_qj[i] == 0 && m_qk[i] == 0 && (p < 0 || m_seq[i] < m_seq[p])) p = i;
        return p;
    endfunction

    function automatic logic [TW-1:0] exec_tag();
        for (int i = 0; i < N; i++) if (m_st[i] == 2) return TW'(TB + i);
        return 4'd0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_seq[i] = 0; m_vj[i] = '0; m_vk[i] = '0;
            m_qj[i] = '0; m_qk[i] = '0; m_op[i] = 1'b0;
        end
        seq_ctr = 0;
    endtask

    // drive one cycle of inputs, check outputs from the current model, advance model
    task automatic step(input string lbl, input bit iv, input bit op,
                        input logic [DW-1:0] vj, input logic [TW-1:0] qj,
                        input logic [DW-1:0] vk, input logic [TW-1:0] qk,
                        input bit cv, input logic [TW-1:0] ct, input logic [DW-1:0] cd,
                        input bit dr);
        int f, p;
        @(negedge clk);
        iss_valid = iv; iss_sub = op; iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
        cdb_valid = cv; cdb_tag = ct; cdb_data = cd; disp_ready = dr;
        #1;
        f = exp_free();
        p = exp_pick();
        chk(iss_ready === (f >= 0), {lbl, " R2 iss_ready"}, DW'(iss_ready), DW'(f >= 0));
        if (f >= 0) chk(iss_tag === TW'(TB + f), {lbl, " R8 iss_tag"}, DW'(iss_tag), DW'(TB + f));
        chk(disp_valid === (p >= 0), {lbl, " R4 disp_valid"}, DW'(disp_valid), DW'(p >= 0));
        if (p >= 0) begin
            chk(disp_tag === TW'(TB + p), {lbl, " R7 disp_tag"}, DW'(disp_tag), DW'(TB + p));
            chk(disp_a === m_vj[p], {lbl, " R5 disp_a"}, disp_a, m_vj[p]);
            chk(disp_b === m_vk[p], {lbl, " R5 disp_b"}, disp_b, m_vk[p]);
            chk(disp_sub === m_op[p], {lbl, " R9 disp_sub"}, DW'(disp_sub), DW'(m_op[p]));
        end
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 1 && cv) begin
                if (m_qj[i] != 0 && m_qj[i] == ct) begin m_vj[i] = cd; m_qj[i] = '0; end
                if (m_qk[i] != 0 && m_qk[i] == ct) begin m_vk[i] = cd; m_qk[i] = '0; end
            end
            if (m_st[i] == 2 && cv && ct == TW'(TB + i)) m_st[i] = 0;
        end
        if (p >= 0 && dr) m_st[p] = 2;
        if (iv && f >= 0) begin
            m_st[f] = 1; m_op[f] = op; m_seq[f] = seq_ctr++;
            if (cv && qj != 0 && ct == qj) begin m_vj[f] = cd; m_qj[f] = '0; end
            else begin m_vj[f] = vj; m_qj[f] = qj; end
            if (cv && qk != 0 && ct == qk) begin m_vk[f] = cd; m_qk[f] = '0; end
            else begin m_vk[f] = vk; m_qk[f] = qk; end
        end
    endtask

    task automatic idle(input string lbl, input bit dr);
        step(lbl, 0, 0, '0, '0, '0, '0, 0, '0, '0, dr);
    endtask

    task automatic bcast(input string lbl, input logic [TW-1:0] t, input logic [DW-1:0] d, input bit dr);
        step(lbl, 0, 0, '0, '0, '0, '0, 1, t, d, dr);
    endtask

    function automatic logic [TW-1:0] rnd_src();
        int r = $urandom % 4;
        if (r < 2) return '0;
        if (r == 2) return TW'(TB + ($urandom % N));
        return TW'(8 + ($urandom % 4));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] ct;
        bit cv;
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        iss_valid = 0; iss_sub = 0; iss_vj = '0; iss_qj = '0; iss_vk = '0; iss_qk = '0;
        cdb_valid = 0; cdb_tag = '0; cdb_data = '0; disp_ready = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        idle("R1", 0);

        // R6: source broadcast in the issue cycle is captured; R9 subtract carried
        step("R6", 1, 1, 64'hDEAD, 4'd9, 64'h1111, 4'd0, 1, 4'd9, 64'hABCD_0001, 0);
        idle("R6", 0);
        idle("R6", 1);
        bcast("R8", 4'd1, 64'h5, 0);
        idle("R8", 0);

        // R3: nonzero tag waits for its broadcast
        step("R3", 1, 0, 64'h7777, 4'd9, 64'h2222, 4'd0, 0, '0, '0, 1);
        idle("R3", 1);
        bcast("R3", 4'd9, 64'h3333_4444, 1);
        idle("R3", 1);
        bcast("R8", 4'd1, 64'h0, 0);

        // R2/R10/R7: fill bank with waiting ops, issue while full, stray tag, then release together
        step("R2", 1, 0, 64'h10, 4'd10, 64'h11, 4'd0, 0, '0, '0, 1);
        step("R2", 1, 1, 64'h20, 4'd0, 64'h21, 4'd10, 0, '0, '0, 1);
        step("R2", 1, 0, 64'h30, 4'd10, 64'h31, 4'd10, 0, '0, '0, 1);
        step("R2", 1, 0, 64'h40, 4'd0, 64'h41, 4'd0, 0, '0, '0, 1);
        bcast("R10", 4'd2, 64'h99, 1);
        idle("R10", 1);
        bcast("R7", 4'd10, 64'hCAFE, 1);
        for (int i = 0; i < 4; i++) idle("R7", 1);
        for (int i = 0; i < N; i++) bcast("R8", TW'(TB + i), 64'h0, 1);
        idle("R8", 1);

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            cv = 0; ct = '0;
            case ($urandom % 3)
                1: begin ct = exec_tag(); cv = (ct != 0); end
                2: begin ct = TW'(8 + ($urandom % 4)); cv = 1; end
                default: ;
            endcase
            step("RND", ($urandom % 2) == 1, ($urandom % 2) == 1,
                 {$urandom, $urandom}, rnd_src(), {$urandom, $urandom}, rnd_src(),
                 cv, ct, {$urandom, $urandom}, ($urandom % 4) != 0);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule